// File: doc/BRIEF.md
# Remote DMA Packet Buffer Engine

This block gives a host processor access to an on-board packet buffer RAM through a small byte-wide register window and a data port. The host programs a start address and a byte count, each in two byte halves. It then writes a command that opens a remote read or a remote write transfer. From then on, every access to the data port moves one byte, or one little-endian 16-bit word when word mode is set. Each access advances the current address and runs the byte count down. When the count reaches zero, the engine raises a completion flag in its status register. The host clears that flag by writing a 1 to it.

The buffer RAM appears at a different window in each data width. In byte mode it is 8 KiB starting at 0x2000. In word mode it is 16 KiB starting at 0x4000. Both windows map onto the same physical storage, starting from its first byte. The host can cancel a transfer at any point with the abort command. The current address is readable at any time, so software can track how far a transfer has gone.

Top module: `rdma_buf_engine`

## Requirements
- R1: After reset the command register (offset 0) reads 0x21, the status register (offset 7) reads 0x80, and the current-address registers (offsets 5 low, 6 high) read 0.
- R2: The start address is written at offsets 1 (low) and 2 (high), and the byte count at offsets 3 (low) and 4 (high); both read back. A command write whose bits 5:3 hold 001 (read) or 010 (write) loads the current address from the start address.
- R3: With configuration register (offset 8) bit 0 clear, each data-port access moves one byte on dp_wdata[7:0] or dp_rdata[7:0] (upper bits read 0) and advances the current address by 1; the RAM window is 0x2000 to 0x3FFF.
- R4: With configuration bit 0 set, each access moves two bytes, the byte at the current address on bits 7:0 and the next byte on bits 15:8, and advances the address by 2; the window is 0x4000 to 0x7FFF, on the same physical storage as the byte window.
- R5: Status bit 6 (transfer done) is set in the cycle after the access that exhausts the programmed count; the transfer then ends.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it; writing 0xFF clears both bit 7 (reset seen) and bit 6.
- R7: A command with bit 5 set (abort) ends an active transfer at once, leaves the current address where it was, and leaves status bit 6 unchanged.
- R8: A byte read from an address outside the active window returns 0xFF, and a byte written there is discarded.
- R9: A data-port access made while no transfer is active, including after completion, changes neither the RAM nor the current address.
- R10: While command bits 7:6 are not 00, writes to offsets other than 0 are ignored and reads from them return 0.
- R11: In word mode with an odd count, the last access still moves two bytes and the count stops at zero rather than going below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_we | input | 1 | Data-port write access |
| dp_re | input | 1 | Data-port read access |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data at the current address |

## Verification
Directed transfers land on the edges of each window. One straddles the low edge of the byte window, which separates discarded and 0xFF bytes from real ones. Another ends at the top of the word window. Odd counts in word mode separate a saturating count from one that wraps. Extra accesses after completion or abort show whether the RAM and the address are truly frozen. Random transfers in both widths are written and then read back against a bench byte model shared between the two windows, which catches any disagreement in lane order or physical mapping between the modes.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 16;
  localparam int REG_W    = 8;
  localparam int ROFF_W   = 4;
  localparam int LANES    = DATA_W / 8;

  // register offsets (page 0)
  localparam logic [ROFF_W-1:0] RG_CMD    = 4'd0;
  localparam logic [ROFF_W-1:0] RG_ADR_LO = 4'd1;
  localparam logic [ROFF_W-1:0] RG_ADR_HI = 4'd2;
  localparam logic [ROFF_W-1:0] RG_LEN_LO = 4'd3;
  localparam logic [ROFF_W-1:0] RG_LEN_HI = 4'd4;
  localparam logic [ROFF_W-1:0] RG_CUR_LO = 4'd5;
  localparam logic [ROFF_W-1:0] RG_CUR_HI = 4'd6;
  localparam logic [ROFF_W-1:0] RG_STAT   = 4'd7;
  localparam logic [ROFF_W-1:0] RG_CFG    = 4'd8;

  // command: [0] stop, [1] start, [2] xmit, [5:3] dma code, [7:6] page
  localparam logic [REG_W-1:0] CMD_RESET = 8'h21;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR, OP_ABORT} dma_op_e;

  function automatic dma_op_e decode_op(input logic [2:0] code);
    if (code[2])          return OP_ABORT;
    else if (code == 3'b001) return OP_RD;
    else if (code == 3'b010) return OP_WR;
    else                  return OP_NONE;
  endfunction

  function automatic logic [ADDR_W-1:0] step_of(input logic word);
    return word ? ADDR_W'(LANES) : ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] next_remain(input logic [ADDR_W-1:0] rem,
                                                    input logic word);
    return (rem <= step_of(word)) ? '0 : rem - step_of(word);
  endfunction
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  dma_op_e           op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] byte_cnt,
  input  logic              word_mode,
  input  logic              acc,
  output logic              active,
  output logic              is_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done_evt,
  output logic              xfer_evt
);
  logic [ADDR_W-1:0] rem_q;
  logic [ADDR_W-1:0] rem_nxt;
  logic              load, abort;

  assign load     = op_valid && (op == OP_RD || op == OP_WR);
  assign abort    = op_valid && (op == OP_ABORT);
  assign xfer_evt = acc && active && !op_valid;
  assign rem_nxt  = next_remain(rem_q, word_mode);
  assign done_evt = (load && byte_cnt == '0) || (xfer_evt && rem_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_write <= 1'b0;
      cur_addr <= '0;
      rem_q    <= '0;
    end else if (load) begin
      active   <= (byte_cnt != '0);
      is_write <= (op == OP_WR);
      cur_addr <= start_addr;
      rem_q    <= byte_cnt;
    end else if (abort) begin
      active   <= 1'b0;
    end else if (xfer_evt) begin
      cur_addr <= cur_addr + step_of(word_mode);
      rem_q    <= rem_nxt;
      if (rem_nxt == '0) active <= 1'b0;
    end
  end

  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !active);

  // R7
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!active && cur_addr == $past(cur_addr)));

  // R9
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> cur_addr == $past(cur_addr));

  // R11
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> rem_q <= $past(rem_q));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> cur_addr == $past(cur_addr) + $past(step_of(word_mode)));
endmodule

// File: rtl/rdma_bufram.sv
module rdma_bufram
  import rdma_pkg::*;
#(
  parameter int LINE_BYTES = 8,
  parameter int BYTE_BASE  = 32'h2000,
  parameter int BYTE_SPAN  = 32'h2000,
  parameter int WORD_BASE  = 32'h4000,
  parameter int WORD_SPAN  = 32'h4000
) (
  input  logic              clk,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int PHYS_BYTES = (WORD_SPAN > BYTE_SPAN) ? WORD_SPAN : BYTE_SPAN;
  localparam int LINES      = PHYS_BYTES / LINE_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(PHYS_BYTES);
  localparam int LINE_W     = IDX_W - OFF_W;

  logic [LINE_BYTES*8-1:0] mem [LINES];

  function automatic logic win_hit(input logic [ADDR_W-1:0] a, input logic w);
    int base, span;
    base = w ? WORD_BASE : BYTE_BASE;
    span = w ? WORD_SPAN : BYTE_SPAN;
    return (int'(a) >= base) && (int'(a) < base + span);
  endfunction

  function automatic logic [IDX_W-1:0] phys_of(input logic [ADDR_W-1:0] a, input logic w);
    int p;
    p = int'(a) - (w ? WORD_BASE : BYTE_BASE);
    return p[IDX_W-1:0];
  endfunction

  logic [LANES-1:0]  hit;
  logic [LINE_W-1:0] line_of [LANES];
  logic [OFF_W-1:0]  off_of  [LANES];
  logic [7:0]        rbyte   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] la;
    logic [IDX_W-1:0]  pa;
    assign la         = addr + ADDR_W'(g);
    assign hit[g]     = win_hit(la, word_mode);
    assign pa         = phys_of(la, word_mode);
    assign line_of[g] = pa[IDX_W-1:OFF_W];
    assign off_of[g]  = pa[OFF_W-1:0];
    assign rbyte[g]   = hit[g] ? mem[line_of[g]][{off_of[g], 3'b000} +: 8] : 8'hFF;
    assign rdata[g*8 +: 8] = (g == 0 || word_mode) ? rbyte[g] : 8'h00;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && hit[l] && (l == 0 || word_mode))
        mem[line_of[l]][{off_of[l], 3'b000} +: 8] <= wdata[l*8 +: 8];
    end
  end
endmodule

// File: rtl/rdma_buf_engine.sv
module rdma_buf_engine
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dp_we,
  input  logic              dp_re,
  input  logic [15:0]       dp_wdata,
  output logic [15:0]       dp_rdata
);
  logic [REG_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] adr_q, len_q, cur_addr;
  logic              word_q, stat_rst, stat_rdc;
  logic              page0, cmd_wr, stat_wr;
  logic              active, is_write, done_evt, xfer_evt;

  assign page0   = (cmd_q[7:6] == 2'b00);
  assign cmd_wr  = reg_we && (reg_addr == RG_CMD);
  assign stat_wr = reg_we && page0 && (reg_addr == RG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RESET;
      adr_q    <= '0;
      len_q    <= '0;
      word_q   <= 1'b0;
      stat_rst <= 1'b1;
      stat_rdc <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= reg_wdata;
      if (reg_we && page0) begin
        unique case (reg_addr)
          RG_ADR_LO: adr_q[7:0]  <= reg_wdata;
          RG_ADR_HI: adr_q[15:8] <= reg_wdata;
          RG_LEN_LO: len_q[7:0]  <= reg_wdata;
          RG_LEN_HI: len_q[15:8] <= reg_wdata;
          RG_CFG:    word_q      <= reg_wdata[0];
          default: ;
        endcase
      end
      if (stat_wr && reg_wdata[7]) stat_rst <= 1'b0;
      if (done_evt)                     stat_rdc <= 1'b1;
      else if (stat_wr && reg_wdata[6]) stat_rdc <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RG_CMD) reg_rdata = cmd_q;
    else if (page0) begin
      unique case (reg_addr)
        RG_ADR_LO: reg_rdata = adr_q[7:0];
        RG_ADR_HI: reg_rdata = adr_q[15:8];
        RG_LEN_LO: reg_rdata = len_q[7:0];
        RG_LEN_HI: reg_rdata = len_q[15:8];
        RG_CUR_LO: reg_rdata = cur_addr[7:0];
        RG_CUR_HI: reg_rdata = cur_addr[15:8];
        RG_STAT:   reg_rdata = {stat_rst, stat_rdc, 6'b0};
        RG_CFG:    reg_rdata = {7'b0, word_q};
        default:   reg_rdata = '0;
      endcase
    end
  end

  rdma_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (cmd_wr),
    .op         (decode_op(reg_wdata[5:3])),
    .start_addr (adr_q),
    .byte_cnt   (len_q),
    .word_mode  (word_q),
    .acc        (dp_we || dp_re),
    .active     (active),
    .is_write   (is_write),
    .cur_addr   (cur_addr),
    .done_evt   (done_evt),
    .xfer_evt   (xfer_evt)
  );

  rdma_bufram u_ram (
    .clk       (clk),
    .word_mode (word_q),
    .addr      (cur_addr),
    .we        (xfer_evt && is_write && dp_we),
    .wdata     (dp_wdata),
    .rdata     (dp_rdata)
  );

  // R6
  w1c_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata == 8'hFF && !done_evt) |=> (!stat_rst && !stat_rdc));

  // R10
  page_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !page0 && reg_addr != RG_CMD) |=>
      (adr_q == $past(adr_q) && len_q == $past(len_q) && word_q == $past(word_q)));

  // R5
  rdc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat_rdc);
endmodule

// File: tb/rdma_buf_engine_tb.sv
`timescale 1ns/1ps
module rdma_buf_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic dp_we = 1'b0, dp_re = 1'b0;
  logic [15:0] dp_wdata = '0, dp_rdata;
  int n_chk = 0, n_fail = 0;
  bit [7:0] mdl [int];

  always #2.5 clk = ~clk;

  rdma_buf_engine u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic dp_wr(input logic [15:0] d);
    @(negedge clk); dp_we = 1'b1; dp_wdata = d;
    @(negedge clk); dp_we = 1'b0;
  endtask

  task automatic dp_rd(output logic [15:0] d);
    @(negedge clk); dp_re = 1'b1; #1; d = dp_rdata;
    @(negedge clk); dp_re = 1'b0;
  endtask

  function automatic bit b_hit(int a, bit w);
    int base = w ? 16384 : 8192;
    return a >= base && a < 2 * base;
  endfunction

  function automatic int b_phys(int a, bit w);
    return a - (w ? 16384 : 8192);
  endfunction

  function automatic logic [7:0] b_byte(int a, bit w);
    if (!b_hit(a, w)) return 8'hFF;
    if (!mdl.exists(b_phys(a, w))) return 8'hxx;
    return mdl[b_phys(a, w)];
  endfunction

  // cmd codes: WR = bits5:3 010 + start, RD = 001 + start, ABORT = 100 + stop
  task automatic setup(input bit w, input int start, input int len, input bit wr);
    reg_wr(4'd8, {7'b0, w});
    reg_wr(4'd1, start[7:0]);  reg_wr(4'd2, start[15:8]);
    reg_wr(4'd3, len[7:0]);    reg_wr(4'd4, len[15:8]);
    reg_wr(4'd7, 8'hFF);
    reg_wr(4'd0, wr ? 8'h12 : 8'h0A);
  endtask

  function automatic int cur_of(input logic [7:0] lo, input logic [7:0] hi);
    return {16'h0, hi, lo};
  endfunction

  task automatic get_cur(output int c);
    logic [7:0] lo, hi;
    reg_rd(4'd5, lo); reg_rd(4'd6, hi);
    c = cur_of(lo, hi);
  endtask

  task automatic model_write(input int a, input bit w, input logic [15:0] d);
    for (int l = 0; l < (w ? 2 : 1); l++)
      if (b_hit(a + l, w)) mdl[b_phys(a + l, w)] = d[l*8 +: 8];
  endtask

  function automatic logic [15:0] exp_read(int a, bit w);
    return w ? {b_byte(a + 1, w), b_byte(a, w)} : {8'h00, b_byte(a, w)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] r8;
    logic [15:0] r16;
    int c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(4'd0, r8); chk("R1 cmd", r8, 8'h21);
    reg_rd(4'd7, r8); chk("R1 stat", r8, 8'h80);
    get_cur(c);       chk("R1 cur", c, 0);

    // R6 write 0 keeps, write 1 clears
    reg_wr(4'd7, 8'h00); reg_rd(4'd7, r8); chk("R6 w0 keeps", r8, 8'h80);

    // R9 prefill 0x2014 = 0x55 (one-byte transfer)
    setup(1'b0, 32'h2014, 1, 1'b1);
    dp_wr(16'h0055); model_write(32'h2014, 1'b0, 16'h0055);

    // R2 / R3 byte-mode write of 4 bytes at 0x2010
    setup(1'b0, 32'h2010, 4, 1'b1);
    reg_rd(4'd1, r8); chk("R2 adr lo", r8, 8'h10);
    reg_rd(4'd4, r8); chk("R2 len hi", r8, 8'h00);
    get_cur(c); chk("R2 cur load", c, 32'h2010);
    for (int i = 0; i < 4; i++) begin
      dp_wr(16'hA0 + 16'(i)); model_write(32'h2010 + i, 1'b0, 16'hA0 + 16'(i));
    end
    get_cur(c); chk("R3 cur step", c, 32'h2014);
    reg_rd(4'd7, r8); chk("R5 done flag", r8, 8'h40);
    // R9 access after completion: no effect
    dp_wr(16'h00EE);
    get_cur(c); chk("R9 cur frozen", c, 32'h2014);
    setup(1'b0, 32'h2010, 5, 1'b0);
    for (int i = 0; i < 5; i++) begin
      dp_rd(r16); chk("R3 byte readback", r16, exp_read(32'h2010 + i, 1'b0));
    end
    chk("R9 ram untouched", mdl[20], 8'h55);

    // R6 selective clear then all
    setup(1'b0, 32'h2100, 1, 1'b1); dp_wr(16'h11); model_write(32'h2100, 1'b0, 16'h11);
    reg_wr(4'd7, 8'h80); reg_rd(4'd7, r8); chk("R6 keep bit6", r8, 8'h40);
    reg_wr(4'd7, 8'h40); reg_rd(4'd7, r8); chk("R6 clear bit6", r8, 8'h00);

    // R4 word mode: 3 words at 0x4000, shares storage with byte window
    setup(1'b1, 32'h4000, 6, 1'b1);
    for (int i = 0; i < 3; i++) begin
      dp_wr(16'h1234 + 16'(i * 16'h0101)); model_write(32'h4000 + 2*i, 1'b1, 16'h1234 + 16'(i * 16'h0101));
    end
    get_cur(c); chk("R4 cur step", c, 32'h4006);
    reg_rd(4'd7, r8); chk("R5 word done", r8, 8'h40);
    setup(1'b0, 32'h2000, 2, 1'b0);
    dp_rd(r16); chk("R4 shared lane0", r16, 16'h0034);
    dp_rd(r16); chk("R4 shared lane1", r16, 16'h0012);

    // R11 odd count in word mode
    setup(1'b1, 32'h4100, 3, 1'b1);
    dp_wr(16'hBEEF); model_write(32'h4100, 1'b1, 16'hBEEF);
    reg_rd(4'd7, r8); chk("R11 not done yet", r8, 8'h00);
    dp_wr(16'hCAFE); model_write(32'h4102, 1'b1, 16'hCAFE);
    reg_rd(4'd7, r8); chk("R11 done", r8, 8'h40);
    get_cur(c); chk("R11 cur", c, 32'h4104);
    dp_wr(16'h9999);
    setup(1'b1, 32'h4100, 4, 1'b0);
    dp_rd(r16); chk("R11 word0", r16, 16'hBEEF);
    dp_rd(r16); chk("R11 word1 both bytes", r16, 16'hCAFE);

    // R7 abort mid transfer
    setup(1'b0, 32'h2200, 10, 1'b1);
    dp_wr(16'h01); model_write(32'h2200, 1'b0, 16'h01);
    dp_wr(16'h02); model_write(32'h2201, 1'b0, 16'h02);
    reg_wr(4'd0, 8'h21);
    reg_rd(4'd7, r8); chk("R7 done unchanged", r8, 8'h00);
    get_cur(c); chk("R7 cur held", c, 32'h2202);
    dp_wr(16'h77);
    get_cur(c); chk("R7 no advance", c, 32'h2202);
    setup(1'b0, 32'h2202, 1, 1'b0);
    dp_rd(r16);
    if (mdl.exists(32'h202)) chk("R7 ram untouched", r16, exp_read(32'h2202, 1'b0));
    else begin
      setup(1'b0, 32'h2202, 1, 1'b1); dp_wr(16'h3C); model_write(32'h2202, 1'b0, 16'h3C);
      setup(1'b0, 32'h2200, 10, 1'b1); dp_wr(16'h01); dp_wr(16'h02);
      reg_wr(4'd0, 8'h21); dp_wr(16'h77);
      setup(1'b0, 32'h2202, 1, 1'b0);
      dp_rd(r16); chk("R7 ram untouched", r16, 16'h003C);
    end

    // R8 out-of-window, byte mode straddling 0x2000
    setup(1'b0, 32'h1FFF, 2, 1'b1);
    dp_wr(16'hAA); dp_wr(16'hBB); model_write(32'h2000, 1'b0, 16'hBB);
    setup(1'b0, 32'h1FFF, 2, 1'b0);
    dp_rd(r16); chk("R8 oob byte read", r16, 16'h00FF);
    dp_rd(r16); chk("R8 in-window byte", r16, 16'h00BB);
    // R8 word mode at top edge
    setup(1'b1, 32'h7FFE, 4, 1'b1);
    dp_wr(16'h5A6B); model_write(32'h7FFE, 1'b1, 16'h5A6B);
    dp_wr(16'h1111);
    setup(1'b1, 32'h7FFE, 4, 1'b0);
    dp_rd(r16); chk("R8 last word", r16, 16'h5A6B);
    dp_rd(r16); chk("R8 oob word", r16, 16'hFFFF);

    // R10 page select
    reg_wr(4'd1, 8'h3C);
    reg_wr(4'd0, 8'h40);
    reg_wr(4'd1, 8'h77);
    reg_rd(4'd1, r8); chk("R10 read zero", r8, 8'h00);
    reg_rd(4'd0, r8); chk("R10 cmd visible", r8, 8'h40);
    reg_wr(4'd0, 8'h01);
    reg_rd(4'd1, r8); chk("R10 write ignored", r8, 8'h3C);

    // random transfers, both widths (R3 R4 R5 R8)
    for (int it = 0; it < 40; it++) begin
      bit w;
      int base, span, start, len, step, n, sel;
      logic [15:0] d;
      w = 1'($urandom % 2);
      base = w ? 16384 : 8192; span = base;
      len = 1 + int'($urandom % 12);
      sel = int'($urandom % 4);
      if (sel == 0)      start = base - 3 + int'($urandom % 6);
      else if (sel == 1) start = base + span - 6 + int'($urandom % 6);
      else               start = base + int'($urandom % (span - 16));
      step = w ? 2 : 1;
      n = (len + step - 1) / step;
      setup(w, start, len, 1'b1);
      for (int i = 0; i < n; i++) begin
        d = 16'($urandom);
        if (!w) d[15:8] = 8'h00;
        dp_wr(d); model_write(start + i * step, w, d);
      end
      get_cur(c); chk(w ? "R4 rand cur" : "R3 rand cur", c, (start + n * step) & 32'hFFFF);
      reg_rd(4'd7, r8); chk("R5 rand done", r8, 8'h40);
      setup(w, start, len, 1'b0);
      for (int i = 0; i < n; i++) begin
        dp_rd(r16); chk(w ? "R4 rand read" : "R3 rand read", r16, exp_read(start + i * step, w));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule